// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and hands the processor one interrupt at a time, together with an 8-bit vector. Lower line numbers win. A request is offered only if it is unmasked and outranks every line already being serviced. Software reaches the controller through a small synchronous register port with three addresses: a command port, a data port and a trigger-mode register.

Before the controller runs, software must program it with a short start-up sequence. One command write opens the sequence. The data-port writes that follow carry the vector base, the cascade word and, if the opening command asked for it, an options word. The options word can enable automatic end-of-interrupt. Once the sequence is complete, data-port writes load the mask. Further command writes select which register the command port reads back, or retire one in-service level.

An acknowledge that finds nothing to serve still returns a vector, that of the lowest-priority line. It leaves in-service empty, so software can recognise the interrupt as spurious.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers read 0x00, command-port reads return the request register, and int_out is low. Until a start-up sequence completes, acknowledges produce no vec_valid and int_out stays low.
- R2: A command write with bit 4 set (0x11 or 0x10) opens the start-up sequence, clears in-service, turns automatic end-of-interrupt off and sets the read-back select to the request register. The next data writes are taken as the vector base and then the cascade word. If bit 0 of the opening command was set, a third data write is taken as the options word. None of these words changes the mask, and the data write after the sequence loads the mask.
- R3: The vector is bits 7:3 of the base word followed by the 3-bit line number; bits 2:0 of the base word are ignored.
- R4: Line 0 has the highest priority. A line is offered only if no in-service bit is set at its own index or at any lower index.
- R5: Outside the sequence, a data write loads the mask, where bit n = 1 blocks line n. A masked request stays in the request register and is offered once it is unmasked.
- R6: int_out rises one clock after a request becomes offerable, and falls one clock after none remains.
- R7: An acknowledge pulse (inta high for one clock) produces, on the next clock, vec_valid high for one cycle with the winner's vector on vec_out. The winner's in-service bit is set and its edge latch is cleared.
- R8: When bit 1 of the options word is set, an acknowledge does not set any in-service bit.
- R9: A command write of 0x60+n (bits 7:5 = 011, bits 4:3 = 00) clears in-service bit n and no other bit.
- R10: A command write with bits 4:3 = 01 and bit 1 set latches bit 0 as the read-back select: 0x0A selects the request register and 0x0B selects in-service. The select holds until it is changed.
- R11: Reads are registered: rd_data shows, one clock later, the register chosen by addr. Address 0 is the command port, address 1 is the mask, address 2 is the trigger register, and address 3 reads zero. A write to address 2 loads the trigger register.
- R12: An acknowledge while no line is offerable returns base+7 and leaves in-service unchanged, even when line 7 is masked.
- R13: Trigger bit n = 1 makes line n level-sensitive, so its request bit follows the input one clock later. Trigger bit n = 0 makes it edge-sensitive: a rising edge sets the request bit, which stays set until that line is acknowledged. The reset value is all edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 command, 1 data/mask, 2 trigger |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_in | input | 8 | Interrupt request lines |
| inta | input | 1 | Acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledge |
| vec_valid | output | 1 | One-cycle flag marking a new vector |

## Verification
The hardest states to reach are those where in-service blocks a request that is already pending. Examples are a lower-priority edge that was latched while a higher line was in service, and a level line that is offered again straight after its end-of-interrupt. The stimulus builds these states in steps: it acknowledges one line, then pulses a lower line and then a higher one, and then retires the levels one at a time. The spurious path is reached by acknowledging with every line masked. A reference model updated on every clock follows each of these steps.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_RUN  = 3'd4
  } cfg_state_t;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_TRIG = 2'd2;

  localparam int INIT_BIT   = 4;
  localparam int OCW3_BIT   = 3;
  localparam int NEED4_BIT  = 0;
  localparam int AEOI_BIT   = 1;
  localparam int RSEL_EN    = 1;
  localparam int RSEL_VAL   = 0;
  localparam logic [2:0] EOI_SPEC = 3'b011;
endpackage

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  trig_q,
  output logic          rd_sel_q,
  output logic [DW-LW-1:0] base_q,
  output logic          aeoi_q,
  output logic          run,
  output logic          init_cmd,
  output logic          eoi_valid,
  output logic [LW-1:0] eoi_idx
);
  cfg_state_t st_q;
  logic need4_q;
  logic is_cmd, is_data, is_trig, cmd_ocw3, cmd_ocw2;

  assign is_cmd   = wr_en && (addr == ADDR_CMD);
  assign is_data  = wr_en && (addr == ADDR_DATA);
  assign is_trig  = wr_en && (addr == ADDR_TRIG);
  assign init_cmd = is_cmd && wr_data[INIT_BIT];
  assign cmd_ocw3 = is_cmd && !wr_data[INIT_BIT] && wr_data[OCW3_BIT];
  assign cmd_ocw2 = is_cmd && !wr_data[INIT_BIT] && !wr_data[OCW3_BIT];
  assign eoi_valid = cmd_ocw2 && (wr_data[DW-1:DW-3] == EOI_SPEC);
  assign eoi_idx   = wr_data[LW-1:0];
  assign run       = (st_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      need4_q  <= 1'b0;
      mask_q   <= '1;
      trig_q   <= '0;
      rd_sel_q <= 1'b0;
      base_q   <= '0;
      aeoi_q   <= 1'b0;
    end else begin
      if (is_trig) trig_q <= wr_data[N-1:0];
      if (init_cmd) begin
        st_q     <= ST_W2;
        need4_q  <= wr_data[NEED4_BIT];
        aeoi_q   <= 1'b0;
        rd_sel_q <= 1'b0;
      end else if (cmd_ocw3 && wr_data[RSEL_EN]) begin
        rd_sel_q <= wr_data[RSEL_VAL];
      end
      if (is_data) begin
        case (st_q)
          ST_W2: begin
            base_q <= wr_data[DW-1:LW];
            st_q   <= ST_W3;
          end
          ST_W3: st_q <= need4_q ? ST_W4 : ST_RUN;
          ST_W4: begin
            aeoi_q <= wr_data[AEOI_BIT];
            st_q   <= ST_RUN;
          end
          default: mask_q <= wr_data[N-1:0];
        endcase
      end
    end
  end

  // R2: the start-up words never disturb the mask
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_W2 || st_q == ST_W3 || st_q == ST_W4) |=> $stable(mask_q));

  // R2: base word is followed by the cascade word
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_W2 && is_data) |=> (st_q == ST_W3));
endmodule

// File: rtl/intc_request.sv
module intc_request #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr_q
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        irr_q[i]  <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= irq_in[i];
        if (trig[i]) irr_q[i] <= irq_in[i];
        else         irr_q[i] <= (irr_q[i] & ~clr[i]) | (irq_in[i] & ~prev_q[i]);
      end
    end

    // R13: a rising edge on an edge line is always captured
    assert_edge_latch_R13: assert property (@(posedge clk) disable iff (rst)
      (!trig[i] && irq_in[i] && !prev_q[i]) |=> irr_q[i]);
  end
endmodule

// File: rtl/intc_resolve.sv
module intc_resolve #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  isr,
  output logic          found,
  output logic [LW-1:0] win_idx,
  output logic [N-1:0]  win_oh
);
  logic [N-1:0] cand;
  logic         blk;

  always_comb begin
    blk  = 1'b0;
    cand = '0;
    for (int i = 0; i < N; i++) begin
      cand[i] = irr[i] & ~mask[i] & ~isr[i] & ~blk;
      blk     = blk | isr[i];
    end
    found   = 1'b0;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found   = 1'b1;
        win_idx = i[LW-1:0];
      end
    end
    win_oh = '0;
    if (found) win_oh[win_idx] = 1'b1;
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [N-1:0]  irq_in,
  input  logic          inta,
  output logic          int_out,
  output logic [DW-1:0] vec_out,
  output logic          vec_valid
);
  localparam int LW = $clog2(N);

  logic [N-1:0] mask_q, trig_q, irr_q, isr_q, win_oh, ack_set, irr_clr, eoi_oh;
  logic rd_sel_q, aeoi_q, run, init_cmd, eoi_valid, found, ack_go;
  logic [DW-LW-1:0] base_q;
  logic [LW-1:0] eoi_idx, win_idx;

  intc_regif #(.N(N), .DW(DW), .LW(LW)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .mask_q(mask_q), .trig_q(trig_q), .rd_sel_q(rd_sel_q), .base_q(base_q),
    .aeoi_q(aeoi_q), .run(run), .init_cmd(init_cmd),
    .eoi_valid(eoi_valid), .eoi_idx(eoi_idx)
  );

  intc_request #(.N(N)) u_req (
    .clk(clk), .rst(rst), .irq_in(irq_in), .trig(trig_q),
    .clr(irr_clr), .irr_q(irr_q)
  );

  intc_resolve #(.N(N), .LW(LW)) u_res (
    .irr(irr_q), .mask(mask_q), .isr(isr_q),
    .found(found), .win_idx(win_idx), .win_oh(win_oh)
  );

  assign ack_go  = inta && run;
  assign irr_clr = (ack_go && found) ? win_oh : '0;
  assign ack_set = (ack_go && found && !aeoi_q) ? win_oh : '0;

  always_comb begin
    eoi_oh = '0;
    if (eoi_valid) eoi_oh[eoi_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q     <= '0;
      int_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      rd_data   <= '0;
    end else begin
      if (init_cmd) isr_q <= '0;
      else          isr_q <= (isr_q & ~eoi_oh) | ack_set;
      int_out   <= run && found;
      vec_valid <= ack_go;
      if (ack_go) vec_out <= {base_q, found ? win_idx : {LW{1'b1}}};
      case (addr)
        ADDR_CMD:  rd_data <= DW'(rd_sel_q ? isr_q : irr_q);
        ADDR_DATA: rd_data <= DW'(mask_q);
        ADDR_TRIG: rd_data <= DW'(trig_q);
        default:   rd_data <= '0;
      endcase
    end
  end

  // R1: no interrupt is raised before the start-up sequence completes
  assert_int_needs_run_R1: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(run));

  // R12: an empty acknowledge yields the lowest-priority line number
  assert_spurious_vec_R12: assert property (@(posedge clk) disable iff (rst)
    (ack_go && !found) |=> (vec_valid && (vec_out[LW-1:0] == {LW{1'b1}})));

  // R12: an empty acknowledge leaves in-service untouched
  assert_spurious_isr_R12: assert property (@(posedge clk) disable iff (rst)
    (ack_go && !found && !eoi_valid && !init_cmd) |=> $stable(isr_q));

  // R9: specific end-of-interrupt clears its level
  assert_eoi_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && !ack_set[eoi_idx]) |=> !isr_q[$past(eoi_idx)]);

  // R3: vector upper bits come from the programmed base
  assert_vec_base_R3: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_out[DW-1:LW] == $past(base_q)));
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic [7:0] irq_in = 8'd0;
  logic inta = 1'b0;
  logic int_out;
  logic [7:0] vec_out;
  logic vec_valid;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit started = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  prio_intc u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_in(irq_in), .inta(inta), .int_out(int_out),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );

  // reference model
  int m_st;
  bit m_need4, m_aeoi, m_rdsel;
  bit [7:0] m_mask, m_trig, m_irr, m_isr, m_prev, m_base;
  bit m_int, m_vv;
  bit [7:0] m_vec, m_rd;

  always @(posedge clk) begin
    int w, low;
    bit [7:0] clr, aset, nirr;
    bit run;
    cycles++;
    if (rst) begin
      m_st = 0; m_need4 = 0; m_aeoi = 0; m_rdsel = 0;
      m_mask = 8'hFF; m_trig = 0; m_irr = 0; m_isr = 0; m_prev = 0; m_base = 0;
      m_int = 0; m_vv = 0; m_vec = 0; m_rd = 0;
      started = 1;
    end else begin
      run = (m_st == 4);
      low = 8;
      for (int i = 7; i >= 0; i--) if (m_isr[i]) low = i;
      w = -1;
      for (int i = 0; i < low; i++) if (w < 0 && m_irr[i] && !m_mask[i]) w = i;
      case (addr)
        2'd0: m_rd = m_rdsel ? m_isr : m_irr;
        2'd1: m_rd = m_mask;
        2'd2: m_rd = m_trig;
        default: m_rd = 0;
      endcase
      m_int = run && (w >= 0);
      m_vv = inta && run;
      clr = 0; aset = 0;
      if (m_vv) begin
        if (w >= 0) begin
          m_vec = m_base | 8'(w);
          clr[w] = 1'b1;
          if (!m_aeoi) aset[w] = 1'b1;
        end else m_vec = m_base | 8'd7;
      end
      for (int i = 0; i < 8; i++)
        nirr[i] = m_trig[i] ? irq_in[i] : ((m_irr[i] & !clr[i]) | (irq_in[i] & !m_prev[i]));
      m_irr = nirr;
      m_prev = irq_in;
      if (wr_en && addr == 2'd0 && wr_data[4]) begin
        m_isr = 0; m_st = 1; m_need4 = wr_data[0]; m_aeoi = 0; m_rdsel = 0;
      end else begin
        if (wr_en && addr == 2'd0 && wr_data[7:3] == 5'b01100)
          m_isr[wr_data[2:0]] = 1'b0;
        m_isr = m_isr | aset;
        if (wr_en && addr == 2'd0 && wr_data[4:3] == 2'b01 && wr_data[1])
          m_rdsel = wr_data[0];
      end
      if (wr_en && addr == 2'd2) m_trig = wr_data;
      if (wr_en && addr == 2'd1) begin
        case (m_st)
          1: begin m_base = wr_data & 8'hF8; m_st = 2; end
          2: m_st = m_need4 ? 3 : 4;
          3: begin m_aeoi = wr_data[1]; m_st = 4; end
          default: m_mask = wr_data;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      n_checks++;
      if (int_out !== m_int || vec_valid !== m_vv || rd_data !== m_rd ||
          (m_vv && vec_out !== m_vec)) begin
        n_fail++;
        $display("FAIL %s cycle %0d: int=%0b/%0b vv=%0b/%0b vec=%02h/%02h rd=%02h/%02h (actual/expected)",
                 cur_req, cycles, int_out, m_int, vec_valid, m_vv, vec_out, m_vec, rd_data, m_rd);
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(output logic [7:0] v, output logic vv);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    v = vec_out; vv = vec_valid;
  endtask

  task automatic pulse(input logic [7:0] lines);
    irq_in = lines;
    @(negedge clk);
    irq_in = 8'd0;
  endtask

  initial begin
    logic [7:0] v;
    logic vv;
    idle(3);
    rst = 1'b0;
    cur_req = "R1";
    rd(2'd1, v); chk(v, 8'hFF, "R1 mask after reset");
    rd(2'd0, v); chk(v, 8'h00, "R1 request after reset");
    chk({7'd0, int_out}, 8'h00, "R1 int_out after reset");
    ack(v, vv); chk({7'd0, vv}, 8'h00, "R1 acknowledge before start-up");

    cur_req = "R2";
    wr(2'd0, 8'h11); wr(2'd1, 8'h23); wr(2'd1, 8'h04); wr(2'd1, 8'h01);
    rd(2'd1, v); chk(v, 8'hFF, "R2 start-up words leave mask");
    cur_req = "R5";
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk(v, 8'h00, "R5 mask load after sequence");

    cur_req = "R7";
    irq_in = 8'h08; idle(2);
    chk({7'd0, int_out}, 8'h01, "R6 int_out for line 3");
    ack(v, vv); chk(v, 8'h23, "R3 vector line 3 with base low bits ignored");
    chk({7'd0, vv}, 8'h01, "R7 vec_valid");
    irq_in = 8'h00;
    wr(2'd0, 8'h0B); rd(2'd0, v); chk(v, 8'h08, "R7 in-service after acknowledge");
    wr(2'd0, 8'h0A); rd(2'd0, v); chk(v, 8'h00, "R13 edge latch cleared by acknowledge");

    cur_req = "R4";
    pulse(8'h20); idle(2);
    chk({7'd0, int_out}, 8'h00, "R4 lower line blocked by in-service");
    rd(2'd0, v); chk(v, 8'h20, "R13 edge latched while blocked");
    pulse(8'h02); idle(2);
    chk({7'd0, int_out}, 8'h01, "R4 higher line offered");
    ack(v, vv); chk(v, 8'h21, "R4 vector line 1");
    wr(2'd0, 8'h0B); rd(2'd0, v); chk(v, 8'h0A, "R7 nested in-service");

    cur_req = "R9";
    wr(2'd0, 8'h61); rd(2'd0, v); chk(v, 8'h08, "R9 EOI clears only bit 1");
    chk(v, 8'h08, "R10 select stays on in-service");
    wr(2'd0, 8'h63); rd(2'd0, v); chk(v, 8'h00, "R9 EOI clears bit 3");
    idle(1);
    chk({7'd0, int_out}, 8'h01, "R4 pending line 5 offered");
    ack(v, vv); chk(v, 8'h25, "R4 vector line 5");
    wr(2'd0, 8'h65);

    cur_req = "R5";
    wr(2'd1, 8'h04); pulse(8'h04); idle(3);
    chk({7'd0, int_out}, 8'h00, "R5 masked line not offered");
    wr(2'd1, 8'h00); idle(2);
    chk({7'd0, int_out}, 8'h01, "R5 unmasked line offered");
    ack(v, vv); chk(v, 8'h22, "R5 vector line 2");
    wr(2'd0, 8'h62);

    cur_req = "R12";
    wr(2'd1, 8'hFF); idle(2);
    ack(v, vv); chk(v, 8'h27, "R12 spurious vector with line 7 masked");
    chk({7'd0, vv}, 8'h01, "R12 spurious vec_valid");
    rd(2'd0, v); chk(v, 8'h00, "R12 in-service empty after spurious");

    cur_req = "R13";
    wr(2'd2, 8'h40); wr(2'd1, 8'h00);
    irq_in = 8'h40; idle(2);
    chk({7'd0, int_out}, 8'h01, "R13 level line offered");
    ack(v, vv); chk(v, 8'h26, "R13 vector line 6");
    wr(2'd0, 8'h66); idle(2);
    chk({7'd0, int_out}, 8'h01, "R13 level line offered again after EOI");
    wr(2'd0, 8'h0A); rd(2'd0, v); chk(v, 8'h40, "R13 level request follows input");
    irq_in = 8'h00; idle(2);
    rd(2'd0, v); chk(v, 8'h00, "R13 level request drops with input");
    cur_req = "R11";
    rd(2'd2, v); chk(v, 8'h40, "R11 trigger register read-back");
    rd(2'd3, v); chk(v, 8'h00, "R11 unused address reads zero");

    cur_req = "R8";
    wr(2'd0, 8'h0B);
    wr(2'd0, 8'h11); wr(2'd1, 8'h40); wr(2'd1, 8'h00); wr(2'd1, 8'h02);
    wr(2'd2, 8'h00);
    pulse(8'h10); idle(1);
    rd(2'd0, v); chk(v, 8'h10, "R2 start-up resets select to request");
    ack(v, vv); chk(v, 8'h44, "R8 vector with new base");
    wr(2'd0, 8'h0B); rd(2'd0, v); chk(v, 8'h00, "R8 automatic EOI leaves in-service empty");

    cur_req = "R2";
    wr(2'd0, 8'h10); wr(2'd1, 8'h8D); wr(2'd1, 8'h00); wr(2'd1, 8'h5A);
    rd(2'd1, v); chk(v, 8'h5A, "R2 third data write is a mask without options word");
    wr(2'd1, 8'h00);
    pulse(8'h01); idle(2);
    ack(v, vv); chk(v, 8'h88, "R3 base 0x8D gives vector 0x88");
    wr(2'd0, 8'h0B); rd(2'd0, v); chk(v, 8'h01, "R2 automatic EOI off after restart");

    idle(2);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule